// File: doc/BRIEF.md
# Video Stream Framing Checker

The framing checker sits beside a pixel stream link and observes it without taking part. It watches the valid/ready handshake, the clock enable, the start-of-frame marker (user sideband bit 0) and the end-of-line marker (last flag). From these it counts accepted pixels per line and completed lines per frame. It confirms that the markers fall on the correct beats and that every frame has the same geometry. It drives nothing toward the link. The only results are three sticky error flags and two measured geometry values.

A beat is accepted only when valid, ready and the clock enable are all high at a rising clock edge, with reset released. Every accepted beat is an active pixel. The start-of-frame beat is pixel 1 of line 0, and the checker restarts its counters on it. The first line of each frame sets the reference line length. Each later line in that frame is compared against it. At each start-of-frame, the number of lines completed in the previous frame is published. That count is then compared with the count from the frame before it.

Top module: `vid_frame_monitor`

## Requirements
- R1: A beat counts only when s_valid, s_ready and clk_en are all 1 at a rising edge of clk. On any other edge, no counter, measurement or flag changes, whatever the markers carry.
- R2: After reset, accepted beats are ignored until the first accepted beat with s_sof = 1.
- R3: An accepted beat with s_sof = 1 restarts counting, and that beat is pixel 1 of line 0 of a new frame. An accepted beat with s_eol = 1 closes the current line.
- R4: When the first line of a frame closes, meas_line_px takes that line's pixel count. The new value is visible from the clock edge that accepts the end-of-line beat.
- R5: A later line of the same frame may close with a pixel count different from meas_line_px, whether shorter or longer. In that case err_line_len becomes 1 from that edge.
- R6: An accepted start-of-frame beat may arrive while the current line has one or more pixels and no end-of-line. In that case err_early_sof becomes 1.
- R7: At each accepted start-of-frame after the first, meas_frame_lines takes the number of lines closed in the frame just ended. If an earlier frame had already been measured and the two counts differ, err_height becomes 1.
- R8: The error flags stay at 1 until clr_err is 1 at a clock edge, which clears them to 0. If a new error is detected on the same edge as the clear, that flag stays 1.
- R9: While rst_n is 0, all flags and both measurements are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Link clock enable; a beat is accepted only when it is 1 |
| s_valid | input | 1 | Observed valid |
| s_ready | input | 1 | Observed ready |
| s_sof | input | 1 | Observed start-of-frame marker (user bit 0) |
| s_eol | input | 1 | Observed end-of-line marker (last flag) |
| clr_err | input | 1 | Clears all sticky error flags |
| err_early_sof | output | 1 | Sticky: start-of-frame arrived inside an open line |
| err_line_len | output | 1 | Sticky: a line length differs from the frame's first line |
| err_height | output | 1 | Sticky: the frame line count changed between frames |
| meas_line_px | output | CNT_W | Pixels in the first line of the current frame |
| meas_frame_lines | output | CNT_W | Lines in the last completed frame |

## Verification
Every result is a register loaded on the edge that accepts the beat that causes it. Each flag and each measurement is therefore final one edge after that beat. The bench drives each beat, waits for the accepting edge, and samples 1 ns after it. This means a check never falls between a beat and its effect. The height measurement is the one delayed result: it appears only at the start-of-frame that follows a frame. The sweeps therefore send a third frame before checking height.

// File: rtl/vfm_pkg.sv
package vfm_pkg;

  localparam int FLG_EARLY_SOF = 0;
  localparam int FLG_LINE_LEN  = 1;
  localparam int FLG_HEIGHT    = 2;
  localparam int NUM_FLAGS     = 3;

  // Position of the current beat inside its line, counted from 1.
  function automatic int unsigned beat_position(input logic starts_frame,
                                                input int unsigned px_so_far);
    return starts_frame ? 32'd1 : px_so_far + 32'd1;
  endfunction

  // Geometry mismatch between a measured and a reference count.
  function automatic logic counts_differ(input int unsigned got,
                                         input int unsigned ref_cnt);
    return got != ref_cnt;
  endfunction

endpackage

// File: rtl/vfm_line_track.sv
module vfm_line_track #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sof,
  input  logic             eol,
  input  logic             first_line,
  input  logic             in_frame,
  output logic [CNT_W-1:0] px_cnt,
  output logic [CNT_W-1:0] ref_len,
  output logic             ev_early_sof,
  output logic             ev_len_bad
);
  logic [CNT_W-1:0] pos;

  assign pos          = CNT_W'(vfm_pkg::beat_position(sof, 32'(px_cnt)));
  assign ev_early_sof = beat & sof & in_frame & (px_cnt != '0);
  assign ev_len_bad   = beat & eol & ~first_line &
                        vfm_pkg::counts_differ(32'(pos), 32'(ref_len));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      px_cnt  <= '0;
      ref_len <= '0;
    end else if (beat) begin
      px_cnt <= eol ? '0 : pos;
      if (eol && first_line) ref_len <= pos;
    end
  end
endmodule

// File: rtl/vfm_frame_track.sv
module vfm_frame_track #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sof,
  input  logic             eol,
  output logic             in_frame,
  output logic             first_line,
  output logic [CNT_W-1:0] frame_lines,
  output logic             ev_height_bad
);
  logic [CNT_W-1:0] lines_cnt;
  logic             have_height;

  assign first_line    = sof | (lines_cnt == '0);
  assign ev_height_bad = beat & sof & in_frame & have_height &
                         vfm_pkg::counts_differ(32'(lines_cnt), 32'(frame_lines));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lines_cnt   <= '0;
      frame_lines <= '0;
      have_height <= 1'b0;
      in_frame    <= 1'b0;
    end else if (beat) begin
      if (sof) begin
        if (in_frame) begin
          frame_lines <= lines_cnt;
          have_height <= 1'b1;
        end
        in_frame  <= 1'b1;
        lines_cnt <= eol ? CNT_W'(1) : '0;
      end else if (eol) begin
        lines_cnt <= lines_cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/vfm_sticky.sv
module vfm_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [N-1:0] set,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)      flag[i] <= 1'b0;
      else if (set[i]) flag[i] <= 1'b1;
      else if (clr)    flag[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/vid_frame_monitor.sv
module vid_frame_monitor #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             s_valid,
  input  logic             s_ready,
  input  logic             s_sof,
  input  logic             s_eol,
  input  logic             clr_err,
  output logic             err_early_sof,
  output logic             err_line_len,
  output logic             err_height,
  output logic [CNT_W-1:0] meas_line_px,
  output logic [CNT_W-1:0] meas_frame_lines
);
  import vfm_pkg::*;

  logic                 ev_xfer;
  logic                 ev_beat;
  logic                 in_frame;
  logic                 first_line;
  logic                 ev_early_sof;
  logic                 ev_len_bad;
  logic                 ev_height_bad;
  logic [CNT_W-1:0]     px_cnt;
  logic [NUM_FLAGS-1:0] flag_set;
  logic [NUM_FLAGS-1:0] flag_q;

  assign ev_xfer = s_valid & s_ready & clk_en;
  assign ev_beat = ev_xfer & (s_sof | in_frame);

  vfm_frame_track #(.CNT_W(CNT_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .beat(ev_beat), .sof(s_sof), .eol(s_eol),
    .in_frame(in_frame), .first_line(first_line),
    .frame_lines(meas_frame_lines), .ev_height_bad(ev_height_bad)
  );

  vfm_line_track #(.CNT_W(CNT_W)) u_line (
    .clk(clk), .rst_n(rst_n), .beat(ev_beat), .sof(s_sof), .eol(s_eol),
    .first_line(first_line), .in_frame(in_frame),
    .px_cnt(px_cnt), .ref_len(meas_line_px),
    .ev_early_sof(ev_early_sof), .ev_len_bad(ev_len_bad)
  );

  assign flag_set[FLG_EARLY_SOF] = ev_early_sof;
  assign flag_set[FLG_LINE_LEN]  = ev_len_bad;
  assign flag_set[FLG_HEIGHT]    = ev_height_bad;

  vfm_sticky #(.N(NUM_FLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .clr(clr_err), .set(flag_set), .flag(flag_q)
  );

  assign err_early_sof = flag_q[FLG_EARLY_SOF];
  assign err_line_len  = flag_q[FLG_LINE_LEN];
  assign err_height    = flag_q[FLG_HEIGHT];
endmodule

// File: rtl/vfm_checker.sv
module vfm_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_err,
  input logic             s_sof,
  input logic             s_eol,
  input logic             ev_xfer,
  input logic             ev_beat,
  input logic             ev_early_sof,
  input logic             ev_len_bad,
  input logic             ev_height_bad,
  input logic [CNT_W-1:0] px_cnt,
  input logic             err_early_sof,
  input logic             err_line_len,
  input logic             err_height,
  input logic [CNT_W-1:0] meas_line_px,
  input logic [CNT_W-1:0] meas_frame_lines
);
  p_no_xfer_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_xfer |=> $stable(px_cnt) && $stable(meas_line_px) && $stable(meas_frame_lines));

  p_sof_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_beat && s_sof && !s_eol |=> px_cnt == CNT_W'(1));

  p_eol_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_beat && s_eol |=> px_cnt == '0);

  p_len_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_len_bad |=> err_line_len);

  p_early_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_early_sof |=> err_early_sof);

  p_height_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_height_bad |=> err_height);

  p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_line_len && !clr_err |=> err_line_len);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err && !ev_early_sof && !ev_len_bad && !ev_height_bad
    |=> !err_early_sof && !err_line_len && !err_height);
endmodule

bind vid_frame_monitor vfm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_err(clr_err), .s_sof(s_sof), .s_eol(s_eol),
  .ev_xfer(ev_xfer), .ev_beat(ev_beat), .ev_early_sof(ev_early_sof),
  .ev_len_bad(ev_len_bad), .ev_height_bad(ev_height_bad), .px_cnt(px_cnt),
  .err_early_sof(err_early_sof), .err_line_len(err_line_len),
  .err_height(err_height), .meas_line_px(meas_line_px),
  .meas_frame_lines(meas_frame_lines)
);

// File: tb/vid_frame_monitor_bench.sv
`timescale 1ns/1ps
module vid_frame_monitor_bench;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_en = 1'b1;
  logic s_valid = 1'b0;
  logic s_ready = 1'b1;
  logic s_sof = 1'b0;
  logic s_eol = 1'b0;
  logic clr_err = 1'b0;
  logic err_early_sof, err_line_len, err_height;
  logic [CNT_W-1:0] meas_line_px, meas_frame_lines;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vid_frame_monitor #(.CNT_W(CNT_W)) u_vid_frame_monitor (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .s_valid(s_valid),
    .s_ready(s_ready), .s_sof(s_sof), .s_eol(s_eol), .clr_err(clr_err),
    .err_early_sof(err_early_sof), .err_line_len(err_line_len),
    .err_height(err_height), .meas_line_px(meas_line_px),
    .meas_frame_lines(meas_frame_lines)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  // Drive one beat, let the edge take it, return 1 ns after that edge.
  task automatic beat(input bit v, input bit r, input bit ce, input bit sof, input bit eol);
    s_valid = v; s_ready = r; clk_en = ce; s_sof = sof; s_eol = eol;
    @(posedge clk); #1;
    s_valid = 0; s_ready = 1; clk_en = 1; s_sof = 0; s_eol = 0;
  endtask

  task automatic pulse_clear();
    clr_err = 1;
    @(posedge clk); #1;
    clr_err = 0;
  endtask

  task automatic send_line(input int w, input bit with_sof, input bit stall);
    for (int p = 0; p < w; p++) begin
      if (stall) begin
        beat(1, 0, 1, 1, 1);   // ready low: ignored
        beat(1, 1, 0, 1, 1);   // clock enable low: ignored
        beat(0, 1, 1, 1, 1);   // valid low: ignored
      end
      beat(1, 1, 1, with_sof && p == 0, p == w - 1);
    end
  endtask

  task automatic send_frame(input int w, input int h, input bit stall);
    for (int l = 0; l < h; l++) send_line(w, l == 0, stall);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9 err_early_sof reset", int'(err_early_sof), 0);
    check("R9 err_line_len reset", int'(err_line_len), 0);
    check("R9 err_height reset", int'(err_height), 0);
    check("R9 meas_line_px reset", int'(meas_line_px), 0);
    check("R9 meas_frame_lines reset", int'(meas_frame_lines), 0);
    rst_n = 1;
    @(posedge clk); #1;

    // R2: beats before any start-of-frame are ignored
    beat(1, 1, 1, 0, 0);
    beat(1, 1, 1, 0, 1);
    beat(1, 1, 1, 0, 1);
    check("R2 meas_line_px before sof", int'(meas_line_px), 0);
    check("R2 err_line_len before sof", int'(err_line_len), 0);

    // Sweep of small geometries, some with stall beats mixed in (R1)
    for (int w = 1; w <= 4; w++) begin
      for (int h = 1; h <= 3; h++) begin
        bit st;
        st = ((w + h) % 2) == 1;
        send_frame(w, h, st);
        send_frame(w, h, st);
        pulse_clear();
        send_frame(w, h, st);
        check($sformatf("R1 R4 meas_line_px w%0d h%0d", w, h), int'(meas_line_px), w);
        check($sformatf("R7 meas_frame_lines w%0d h%0d", w, h), int'(meas_frame_lines), h);
        check($sformatf("R5 err_line_len w%0d h%0d", w, h), int'(err_line_len), 0);
        check($sformatf("R6 err_early_sof w%0d h%0d", w, h), int'(err_early_sof), 0);
        check($sformatf("R7 err_height w%0d h%0d", w, h), int'(err_height), 0);
      end
    end

    // R5: short line then long line
    pulse_clear();
    send_line(3, 1, 0);
    check("R4 reference line length", int'(meas_line_px), 3);
    send_line(2, 0, 0);
    check("R5 short line flagged", int'(err_line_len), 1);
    pulse_clear();
    check("R8 clear drops flag", int'(err_line_len), 0);
    send_line(4, 0, 0);
    check("R5 long line flagged", int'(err_line_len), 1);
    repeat (4) beat(0, 1, 1, 0, 1);
    beat(1, 1, 0, 1, 1);
    check("R8 flag holds without clear", int'(err_line_len), 1);
    check("R1 gated beat leaves length", int'(meas_line_px), 3);
    pulse_clear();
    // R8: error on the same edge as clear keeps the flag
    beat(1, 1, 1, 0, 0);
    clr_err = 1;
    beat(1, 1, 1, 0, 1);
    clr_err = 0;
    check("R8 set wins over clear", int'(err_line_len), 1);
    pulse_clear();

    // R6: start-of-frame inside an open line, R3 counters restart
    beat(1, 1, 1, 0, 0);
    beat(1, 1, 1, 0, 0);
    beat(1, 1, 1, 1, 0);
    check("R6 early sof flagged", int'(err_early_sof), 1);
    beat(1, 1, 1, 0, 0);
    beat(1, 1, 1, 0, 1);
    check("R3 sof beat is pixel one", int'(meas_line_px), 3);
    pulse_clear();

    // R7: height change between frames
    send_frame(2, 2, 0);
    send_frame(2, 2, 0);
    pulse_clear();
    send_frame(2, 3, 0);
    check("R7 equal heights no flag", int'(err_height), 0);
    check("R7 height published", int'(meas_frame_lines), 2);
    beat(1, 1, 1, 1, 1);
    check("R7 height change flagged", int'(err_height), 1);
    check("R7 new height published", int'(meas_frame_lines), 3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule